// File: doc/BRIEF.md
# Per-Pixel Direct/Indexed Colour Selector

This block is a streaming stage in a display scanout path. Each incoming pixel carries three values: an 8-bit palette index, a 32-bit true-colour word and a 32-bit control word. A tag byte in the control word chooses how that one pixel is coloured. With the direct tag, the pixel's colour comes straight from the true-colour word, with its channels reordered. With any other tag, the index addresses an external 256-entry palette store and the entry that comes back is the colour. Because the mode is chosen per pixel, direct and indexed pixels can be mixed freely on one line.

Pixels enter and leave on valid/ready streams. The palette store is read through a simple port that returns data one cycle after the request. The block keeps pixel order across both colour paths and tolerates any back-pressure pattern on the output. A counter of visible pixels raises a line-end flag on the last pixel of every line. That counter is sized from the fixed line pitch, so any visible width up to the pitch fits.

Top module: `pxsel_top`

## Requirements
- R1: A pixel is direct when bits 31:24 of its control word equal 8'h03; any other value of that byte makes the pixel indexed.
- R2: Bits 23:0 of the control word never affect the chosen mode or the output colour.
- R3: For a direct pixel, bits 31:24 of the true-colour word never affect the output colour.
- R4: For a direct pixel, the true-colour word holds blue in bits 23:16, green in bits 15:8 and red in bits 7:0, and the output `out_rgb` carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R5: When an indexed pixel is accepted, `pal_rd_en` is high in that same cycle with `pal_rd_addr` equal to the index. The 24-bit `pal_rd_data` returned in the next cycle becomes the pixel's output colour, unchanged. `pal_rd_en` is low in every cycle in which no indexed pixel is accepted.
- R6: Output pixels leave in the order they were accepted, whatever their modes.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_rgb` and `out_line_end` hold steady. Every accepted pixel leaves exactly once, and the block holds no more than two pixels.
- R8: A palette entry that arrives while the output is stalled is kept until that pixel leaves. Later values on `pal_rd_data` do not alter it.
- R9: `out_line_end` is high exactly on output pixels whose position in the line, counted from 0 since reset, equals VIS_WIDTH-1. The count then restarts at 0. VIS_WIDTH may be any value up to the line pitch (parameter PITCH, 1024).
- R10: After reset, `out_valid` is low and `in_ready` is high.
- R11: While `out_ready` stays high, one pixel is accepted in every cycle that `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_index | input | 8 | Palette index for the pixel |
| in_direct | input | 32 | True-colour word, blue/green/red in bits 23:0 |
| in_ctrl | input | 32 | Control word; tag in bits 31:24 |
| pal_rd_en | output | 1 | Palette read request |
| pal_rd_addr | output | 8 | Palette entry address |
| pal_rd_data | input | 24 | Palette entry {R,G,B}, one cycle after request |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the pixel |
| out_rgb | output | 24 | Output colour {R,G,B} |
| out_line_end | output | 1 | Last visible pixel of the line |

## Verification
The main collision is a palette return landing in the same cycle that the output register is stalled. In that cycle the pixel's colour must be captured in the holding slot, while a new pixel may also be accepted or refused on the same edge. The bench provokes this with random output stalls over mixed direct and indexed traffic, and with a held stall of several cycles. During that stall the palette port carries changing junk. The bench's queue model predicts every output value and line-end flag. The hold rule is checked in each stalled cycle.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;

    localparam int IDX_W  = 8;
    localparam int WORD_W = 32;
    localparam int CH_W   = 8;
    localparam int COL_W  = 3 * CH_W;
    localparam int TAG_W  = 8;
    localparam int TAG_LO = WORD_W - TAG_W;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic {
        MODE_INDEXED = 1'b0,
        MODE_DIRECT  = 1'b1
    } pix_mode_e;

    // holding slot: pixel accepted, palette data possibly still in flight
    typedef struct packed {
        logic      vld;
        pix_mode_e mode;
        logic      fresh;
        rgb_t      col;
        logic      last;
    } hold_slot_t;

    typedef struct packed {
        logic vld;
        rgb_t col;
        logic last;
    } out_slot_t;

    typedef struct packed {
        hold_slot_t hold;
        out_slot_t  outp;
    } pipe_st_t;

    // true-colour word keeps channels low-to-high as red, green, blue
    function automatic rgb_t unpack_bgr(input logic [WORD_W-1:0] w);
        rgb_t c;
        c.r = w[CH_W-1:0];
        c.g = w[2*CH_W-1:CH_W];
        c.b = w[3*CH_W-1:2*CH_W];
        return c;
    endfunction

endpackage

// File: rtl/pxsel_classify.sv
module pxsel_classify
    import pxsel_pkg::*;
#(
    parameter logic [TAG_W-1:0] DIRECT_TAG = 8'h03
) (
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic [WORD_W-1:0] direct_word,
    output pix_mode_e         mode,
    output rgb_t              direct_col
);

    logic [TAG_W-1:0] tag;
    logic             unused_bits;

    assign tag         = ctrl_word[WORD_W-1:TAG_LO];
    assign unused_bits = ^{ctrl_word[TAG_LO-1:0], direct_word[WORD_W-1:COL_W]};

    always_comb begin
        mode = (tag == DIRECT_TAG) ? MODE_DIRECT : MODE_INDEXED;
    end

    assign direct_col = unpack_bgr(direct_word);

endmodule

// File: rtl/pxsel_linecnt.sv
module pxsel_linecnt #(
    parameter int VIS_WIDTH = 640,
    parameter int PITCH     = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic at_end
);

    localparam int CNT_W = (PITCH > 1) ? $clog2(PITCH) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(VIS_WIDTH - 1);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    assign at_end = (st_q.pos == LAST_POS);

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (at_end) begin
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pxsel_pipe.sv
module pxsel_pipe
    import pxsel_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_valid,
    output logic      up_ready,
    input  pix_mode_e up_mode,
    input  rgb_t      up_col,
    input  logic      up_last,
    input  rgb_t      pal_col,
    output logic      dn_valid,
    input  logic      dn_ready,
    output rgb_t      dn_col,
    output logic      dn_last
);

    pipe_st_t st_d, st_q;
    logic     hold_move;
    logic     up_fire;
    rgb_t     hold_col_now;

    // holding slot advances when the output slot is empty or draining
    assign hold_move = st_q.hold.vld && (!st_q.outp.vld || dn_ready);
    assign up_ready  = !st_q.hold.vld || hold_move;
    assign up_fire   = up_valid && up_ready;

    // palette data is only on the port in the cycle after the request
    always_comb begin
        if (st_q.hold.mode == MODE_INDEXED && st_q.hold.fresh) begin
            hold_col_now = pal_col;
        end else begin
            hold_col_now = st_q.hold.col;
        end
    end

    always_comb begin
        st_d = st_q;

        if (st_q.outp.vld && dn_ready) begin
            st_d.outp.vld = 1'b0;
        end

        if (hold_move) begin
            st_d.outp.vld  = 1'b1;
            st_d.outp.col  = hold_col_now;
            st_d.outp.last = st_q.hold.last;
            st_d.hold.vld  = 1'b0;
        end else if (st_q.hold.vld) begin
            st_d.hold.col = hold_col_now;
        end
        st_d.hold.fresh = 1'b0;

        if (up_fire) begin
            st_d.hold.vld   = 1'b1;
            st_d.hold.mode  = up_mode;
            st_d.hold.fresh = (up_mode == MODE_INDEXED);
            st_d.hold.col   = up_col;
            st_d.hold.last  = up_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dn_valid = st_q.outp.vld;
    assign dn_col   = st_q.outp.col;
    assign dn_last  = st_q.outp.last;

endmodule

// File: rtl/pxsel_top.sv
module pxsel_top
    import pxsel_pkg::*;
#(
    parameter int              VIS_WIDTH  = 640,
    parameter int              PITCH      = 1024,
    parameter logic [TAG_W-1:0] DIRECT_TAG = 8'h03
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [WORD_W-1:0] in_direct,
    input  logic [WORD_W-1:0] in_ctrl,
    output logic              pal_rd_en,
    output logic [IDX_W-1:0]  pal_rd_addr,
    input  logic [COL_W-1:0]  pal_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [COL_W-1:0]  out_rgb,
    output logic              out_line_end
);

    pix_mode_e pix_mode;
    rgb_t      dir_col;
    rgb_t      pal_col;
    rgb_t      res_col;
    logic      line_last;
    logic      accept;

    assign accept  = in_valid && in_ready;
    assign pal_col = rgb_t'(pal_rd_data);

    pxsel_classify #(
        .DIRECT_TAG (DIRECT_TAG)
    ) u_classify (
        .ctrl_word   (in_ctrl),
        .direct_word (in_direct),
        .mode        (pix_mode),
        .direct_col  (dir_col)
    );

    pxsel_linecnt #(
        .VIS_WIDTH (VIS_WIDTH),
        .PITCH     (PITCH)
    ) u_linecnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (accept),
        .at_end (line_last)
    );

    pxsel_pipe u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_mode  (pix_mode),
        .up_col   (dir_col),
        .up_last  (line_last),
        .pal_col  (pal_col),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_col   (res_col),
        .dn_last  (out_line_end)
    );

    assign pal_rd_en   = accept && (pix_mode == MODE_INDEXED);
    assign pal_rd_addr = in_index;
    assign out_rgb     = res_col;

endmodule

// File: rtl/pxsel_chk.sv
module pxsel_chk #(
    parameter int         VIS_WIDTH  = 640,
    parameter logic [7:0] DIRECT_TAG = 8'h03
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic [7:0]  ctrl_tag,
    input logic        pal_rd_en,
    input logic        out_valid,
    input logic        out_ready,
    input logic [23:0] out_rgb,
    input logic        out_line_end
);

    int unsigned occ;
    int unsigned emit_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ      <= 0;
            emit_pos <= 0;
        end else begin
            occ <= occ + ((in_valid && in_ready) ? 1 : 0)
                       - ((out_valid && out_ready) ? 1 : 0);
            if (out_valid && out_ready) begin
                emit_pos <= (emit_pos == VIS_WIDTH - 1) ? 0 : emit_pos + 1;
            end
        end
    end

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_line_end)); // R7

    AST_READ_ONLY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        pal_rd_en |-> in_valid && in_ready); // R5

    AST_DIRECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && ctrl_tag == DIRECT_TAG |-> !pal_rd_en); // R1

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= 2); // R7

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        occ == 2 && !out_ready |-> !in_ready); // R7

    AST_LINE_END_POS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready |-> out_line_end == (emit_pos == VIS_WIDTH - 1)); // R9

endmodule

bind pxsel_top pxsel_chk #(
    .VIS_WIDTH  (VIS_WIDTH),
    .DIRECT_TAG (DIRECT_TAG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .ctrl_tag     (in_ctrl[31:24]),
    .pal_rd_en    (pal_rd_en),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_rgb      (out_rgb),
    .out_line_end (out_line_end)
);

// File: tb/pxsel_top_tb.sv
`timescale 1ns/1ps
module pxsel_top_tb;

    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_index = '0;
    logic [31:0] in_direct = '0;
    logic [31:0] in_ctrl = '0;
    logic        pal_rd_en;
    logic [7:0]  pal_rd_addr;
    logic [23:0] pal_rd_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_rgb;
    logic        out_line_end;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int n_in = 0;
    int n_out = 0;
    int n_lines = 0;
    int in_pos = 0;
    bit done = 1'b0;
    string cur_req = "R6";

    logic [23:0] q_rgb[$];
    logic        q_last[$];
    string       q_req[$];

    bit          prev_stall = 1'b0;
    logic [23:0] prev_rgb = '0;
    logic        prev_last = 1'b0;

    always #2 clk = ~clk;

    pxsel_top #(.VIS_WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl),
        .pal_rd_en(pal_rd_en), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
        .out_line_end(out_line_end)
    );

    function automatic logic [23:0] palf(input logic [7:0] i);
        return {i ^ 8'h3c, i + 8'd17, ~i};
    endfunction

    // external palette store: one cycle latency, junk when not read
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pal_rd_en) pal_rd_data <= palf(pal_rd_addr);
        else           pal_rd_data <= 24'hA5C3E1 ^ 24'(cyc * 7919);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit iv, input logic [7:0] idx, input logic [31:0] dir,
                        input logic [31:0] ctl, input bit ordy, input bit want_thru);
        logic [23:0] e_rgb;
        bit          is_dir;
        @(negedge clk);
        in_valid = iv; in_index = idx; in_direct = dir; in_ctrl = ctl; out_ready = ordy;
        #1;
        if (prev_stall) begin
            check(out_valid == 1'b1, "R7", "valid dropped in stall", 32'(out_valid), 32'd1);
            check(out_rgb == prev_rgb && out_line_end == prev_last, "R7", "data moved in stall",
                  32'(out_rgb), 32'(prev_rgb));
        end
        if (out_valid) begin
            if (q_rgb.size() == 0) begin
                check(1'b0, "R7", "output with nothing pending", 32'(out_rgb), 32'd0);
            end else begin
                check(out_rgb == q_rgb[0], q_req[0], "colour", 32'(out_rgb), 32'(q_rgb[0]));
                check(out_line_end == q_last[0], "R9", "line end", 32'(out_line_end),
                      32'(q_last[0]));
            end
        end
        if (want_thru && iv) check(in_ready == 1'b1, "R11", "stall under free flow",
                                   32'(in_ready), 32'd1);
        if (out_valid && out_ready) begin
            n_out++;
            if (out_line_end) n_lines++;
            if (q_rgb.size() != 0) begin
                void'(q_rgb.pop_front()); void'(q_last.pop_front()); void'(q_req.pop_front());
            end
        end
        if (iv && in_ready) begin
            is_dir = (ctl[31:24] == 8'h03);
            e_rgb  = is_dir ? {dir[7:0], dir[15:8], dir[23:16]} : palf(idx);
            q_rgb.push_back(e_rgb);
            q_last.push_back(in_pos == W - 1);
            q_req.push_back(cur_req);
            in_pos = (in_pos == W - 1) ? 0 : in_pos + 1;
            n_in++;
            if (is_dir) check(pal_rd_en == 1'b0, "R5", "read on direct pixel", 32'(pal_rd_en), 32'd0);
            else check(pal_rd_en == 1'b1 && pal_rd_addr == idx, "R5", "palette request",
                       {23'd0, pal_rd_en, pal_rd_addr}, {23'd0, 1'b1, idx});
        end else begin
            check(pal_rd_en == 1'b0, "R5", "read without accept", 32'(pal_rd_en), 32'd0);
        end
        prev_stall = out_valid && !out_ready;
        prev_rgb   = out_rgb;
        prev_last  = out_line_end;
    endtask

    task automatic pix(input string req, input logic [7:0] idx, input logic [31:0] dir,
                       input logic [31:0] ctl);
        cur_req = req;
        step(1'b1, idx, dir, ctl, 1'b1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10", "valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "idle after reset",
              {30'd0, out_valid, in_ready}, 32'd1);

        // direct tag with junk in the ignored bytes
        pix("R4", 8'h11, 32'h00_112233, 32'h0300_0000);
        pix("R3", 8'h22, 32'hAB_445566, 32'h0300_0000);
        pix("R2", 8'h33, 32'hFF_778899, 32'h03FF_FFFF);
        pix("R1", 8'h44, 32'h12_345678, 32'h0312_3456);
        // near-miss tags are indexed
        pix("R1", 8'h05, 32'h00_ABCDEF, 32'h0200_0000);
        pix("R1", 8'h06, 32'h00_ABCDEF, 32'h0400_0000);
        pix("R1", 8'h07, 32'h00_ABCDEF, 32'h8300_0000);
        pix("R1", 8'h08, 32'h00_ABCDEF, 32'h1300_0000);
        pix("R2", 8'h09, 32'h00_ABCDEF, 32'h0000_0003);
        pix("R5", 8'hFF, 32'h00_ABCDEF, 32'hFF03_0303);
        pix("R5", 8'h00, 32'h00_ABCDEF, 32'h0000_0000);

        // free-flowing mixed stream
        cur_req = "R6";
        for (int i = 0; i < 40; i++) begin
            step(1'b1, 8'(i * 37), {8'(i), 24'(i * 40503)},
                 ((i % 3) == 0) ? 32'h0300_0000 : {8'(i), 24'h0}, 1'b1, 1'b1);
        end

        // random traffic and back-pressure
        for (int i = 0; i < 400; i++) begin
            cur_req = ($urandom_range(0, 1) == 0) ? "R6" : "R7";
            step(($urandom_range(0, 3) != 0), 8'($urandom), $urandom,
                 ($urandom_range(0, 1) == 0) ? {8'h03, 24'($urandom)} : $urandom,
                 ($urandom_range(0, 1) == 0), 1'b0);
        end

        // long stall while palette returns and then changes
        step(1'b0, 8'h00, 32'h0, 32'h0, 1'b1, 1'b0);
        step(1'b0, 8'h00, 32'h0, 32'h0, 1'b1, 1'b0);
        step(1'b0, 8'h00, 32'h0, 32'h0, 1'b1, 1'b0);
        cur_req = "R8";
        step(1'b1, 8'h5A, 32'h0, 32'h0100_0000, 1'b0, 1'b0);
        step(1'b1, 8'hC7, 32'h0, 32'h0100_0000, 1'b0, 1'b0);
        step(1'b1, 8'h21, 32'h0, 32'h0100_0000, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 8'h00, 32'h0, 32'h0, 1'b0, 1'b0);

        // drain
        for (int i = 0; i < 10; i++) step(1'b0, 8'h00, 32'h0, 32'h0, 1'b1, 1'b0);
        check(q_rgb.size() == 0 && n_in == n_out, "R7", "pixels lost or duplicated",
              32'(n_out), 32'(n_in));
        check(n_lines == n_in / W, "R9", "line end count", 32'(n_lines), 32'(n_in / W));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule